// File: doc/BRIEF.md
# Line Readout Sequencer with Horizontal Binning

This block drives the readout of a linear pixel array. After an accepted start it sends out one pixel address per clock, ascending or descending, over either the whole array or a centred window that covers the middle half. The sampled values come back on a separate valid/data stream in the order they were requested. The block averages them over groups of 1, 2 or 4 neighbouring pixels and presents one result per group. A one-cycle completion pulse marks the end of the line.

Each group is aligned to a multiple of the binning factor. A descending scan therefore yields the highest group first, and each group still covers pixels 4k..4k+3 (or 2k..2k+1). Averaging truncates: the group sum is shifted right by 1 or 2 bits. Direction, window and binning are captured on the start that is accepted. Later changes to these inputs, and further start pulses, are ignored until the line has finished. A configuration that pairs 2-pixel binning with single-ended output mode is refused. So is the unused binning code. A refused start raises the error flag and starts nothing.

Control is one state machine:
- `ST_IDLE` waits for a start.
- `ST_SCAN` issues one address per cycle.
- `ST_DRAIN` waits for the samples still outstanding.
- `ST_FLUSH` is the cycle in which the last average is visible.
- `ST_DONE` raises the completion pulse.

The transitions are:
- IDLE→SCAN on a legal start.
- SCAN→DRAIN once the final address has been issued.
- SCAN or DRAIN→FLUSH when the final sample is taken.
- FLUSH→DONE, then DONE→IDLE, unconditionally.
- IDLE→IDLE on a refused start.

Top module: `line_readout_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `pix_req_valid`, `out_valid`, `line_done`, `busy` and `cfg_err` are all 0.
- R2: With `dir_rev`=0, a legal start sampled on a clock edge makes `pix_req_valid` high from that edge on. The addresses run in ascending order, one per cycle, from the window's lowest pixel to its highest.
- R3: With `dir_rev`=1, the addresses run in descending order from the window's highest pixel to its lowest, one per cycle.
- R4: With `roi_en`=0 the window is pixels 0 to NUM_PIX-1. With `roi_en`=1 it is pixels NUM_PIX/4 to 3*NUM_PIX/4-1, which is 256 to 767 at the default size.
- R5: `bin_sel` code 0 selects 1 pixel, code 1 selects 2 and code 2 selects 4. Each `out_data` is the sum of that many consecutive returned samples shifted right by 0, 1 or 2 bits, with truncation. A line yields its window length divided by the factor in results.
- R6: Groups are aligned to multiples of the binning factor in either direction. In a descending scan the highest-numbered group comes out first.
- R7: A start in idle with `bin_sel`=1 and `diff_mode`=0, or with `bin_sel`=3, sets `cfg_err`. It issues no address and leaves `busy` low.
- R8: `cfg_err` holds its value until the next accepted start, which clears it.
- R9: `line_done` is high for exactly one cycle, the cycle after the line's last `out_valid`. `busy` is low in the cycle that follows.
- R10: A start while `busy` is high has no effect. The address sequence and the averaging of the running line are unchanged.
- R11: Samples presented while idle are ignored. They produce no result and do not disturb the averages of the next line.
- R12: The accumulator does not overflow. Full-scale samples average to full scale at every binning factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a line readout (acted on only when idle) |
| dir_rev | input | 1 | 0 ascending scan, 1 descending scan |
| roi_en | input | 1 | 0 full array, 1 centre half |
| bin_sel | input | 2 | Binning code: 0 one, 1 two, 2 four, 3 illegal |
| diff_mode | input | 1 | 1 differential output, 0 single-ended |
| smp_valid | input | 1 | Returned sample valid |
| smp_data | input | SAMPLE_W | Returned sample value |
| pix_req_valid | output | 1 | Address request valid |
| pix_idx | output | clog2(NUM_PIX) | Requested pixel address |
| out_valid | output | 1 | Averaged result valid |
| out_data | output | SAMPLE_W | Averaged result |
| line_done | output | 1 | One-cycle end-of-line pulse |
| busy | output | 1 | Readout in progress |
| cfg_err | output | 1 | Last start was refused |

## Verification
The bench builds the block with NUM_PIX=64 and SAMPLE_W=8. The window is then pixels 16 to 47, and a full line is short enough to run every combination of direction, window and binning factor from end to end. Eight-bit samples reach full scale easily, so the all-ones pattern exercises the widest group sums. The bench answers requests after a delay and leaves a gap every fourth cycle, so the DRAIN state and completion after the final address are both covered.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN,
        ST_FLUSH,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] BIN_X1 = 2'd0;
    localparam logic [1:0] BIN_X2 = 2'd1;
    localparam logic [1:0] BIN_X4 = 2'd2;

    // two-pixel grouping needs the differential output path
    function automatic logic cfg_legal(input logic [1:0] code, input logic diff);
        return (code == BIN_X1) || (code == BIN_X4) || ((code == BIN_X2) && diff);
    endfunction

    function automatic logic [1:0] bin_shift(input logic [1:0] code);
        return (code == BIN_X4) ? 2'd2 : ((code == BIN_X2) ? 2'd1 : 2'd0);
    endfunction

endpackage

// File: rtl/lsq_addr_gen.sv
module lsq_addr_gen #(
    parameter int NUM_PIX = 1024,
    parameter int IDX_W   = $clog2(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             rev,
    input  logic             roi,
    output logic [IDX_W-1:0] idx,
    output logic             at_end
);

    localparam int WIN_LO  = NUM_PIX / 4;
    localparam int WIN_HI  = (3 * NUM_PIX) / 4 - 1;
    localparam int FULL_HI = NUM_PIX - 1;

    logic [IDX_W-1:0] first_w;
    logic [IDX_W-1:0] last_w;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] end_q;
    logic             rev_q;

    always_comb begin
        if (roi) begin
            first_w = rev ? IDX_W'(WIN_HI) : IDX_W'(WIN_LO);
            last_w  = rev ? IDX_W'(WIN_LO) : IDX_W'(WIN_HI);
        end else begin
            first_w = rev ? IDX_W'(FULL_HI) : '0;
            last_w  = rev ? '0 : IDX_W'(FULL_HI);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            end_q <= '0;
            rev_q <= 1'b0;
        end else if (load) begin
            cur_q <= first_w;
            end_q <= last_w;
            rev_q <= rev;
        end else if (step) begin
            cur_q <= rev_q ? cur_q - 1'b1 : cur_q + 1'b1;
        end
    end

    assign idx    = cur_q;
    assign at_end = (cur_q == end_q);

endmodule

// File: rtl/lsq_bin_avg.sv
module lsq_bin_avg #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [1:0]          shift,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);

    localparam int SUM_W = SAMPLE_W + 2;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_nx;
    logic [1:0]       cnt_q;
    logic             grp_last;

    assign sum_nx = sum_q + SUM_W'(in_data);

    always_comb begin
        unique case (shift)
            2'd0:    grp_last = 1'b1;
            2'd1:    grp_last = cnt_q[0];
            default: grp_last = (cnt_q == 2'd3);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q     <= '0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (clear) begin
                sum_q <= '0;
                cnt_q <= '0;
            end else if (in_valid) begin
                if (grp_last) begin
                    out_data  <= SAMPLE_W'(sum_nx >> shift);
                    out_valid <= 1'b1;
                    sum_q     <= '0;
                    cnt_q     <= '0;
                end else begin
                    sum_q <= sum_nx;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/line_readout_seq.sv
module line_readout_seq
    import lsq_pkg::*;
#(
    parameter int NUM_PIX  = 1024,
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       dir_rev,
    input  logic                       roi_en,
    input  logic [1:0]                 bin_sel,
    input  logic                       diff_mode,
    input  logic                       smp_valid,
    input  logic [SAMPLE_W-1:0]        smp_data,
    output logic                       pix_req_valid,
    output logic [$clog2(NUM_PIX)-1:0] pix_idx,
    output logic                       out_valid,
    output logic [SAMPLE_W-1:0]        out_data,
    output logic                       line_done,
    output logic                       busy,
    output logic                       cfg_err
);

    localparam int IDX_W = $clog2(NUM_PIX);
    localparam int CNT_W = $clog2(NUM_PIX + 1);

    seq_state_t state_q, state_d;

    logic             start_ok, start_bad;
    logic             cfg_roi_q;
    logic [1:0]       cfg_shift_q;
    logic             at_end;
    logic             rx_take, rx_last;
    logic [CNT_W-1:0] rx_cnt_q;
    logic [CNT_W-1:0] rx_total;

    assign start_ok  = start && (state_q == ST_IDLE) && cfg_legal(bin_sel, diff_mode);
    assign start_bad = start && (state_q == ST_IDLE) && !cfg_legal(bin_sel, diff_mode);

    assign rx_take  = smp_valid && ((state_q == ST_SCAN) || (state_q == ST_DRAIN));
    assign rx_total = cfg_roi_q ? CNT_W'(NUM_PIX / 2) : CNT_W'(NUM_PIX);
    assign rx_last  = rx_take && (rx_cnt_q == rx_total - CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_SCAN;
            ST_SCAN: begin
                if (rx_last)     state_d = ST_FLUSH;
                else if (at_end) state_d = ST_DRAIN;
            end
            ST_DRAIN: if (rx_last) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        pix_req_valid = (state_q == ST_SCAN);
        line_done     = (state_q == ST_DONE);
        busy          = (state_q != ST_IDLE);
    end

    // captured configuration, sample count and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_roi_q   <= 1'b0;
            cfg_shift_q <= 2'd0;
            rx_cnt_q    <= '0;
            cfg_err     <= 1'b0;
        end else begin
            if (start_ok) begin
                cfg_roi_q   <= roi_en;
                cfg_shift_q <= bin_shift(bin_sel);
                rx_cnt_q    <= '0;
                cfg_err     <= 1'b0;
            end else begin
                if (start_bad) cfg_err <= 1'b1;
                if (rx_take)   rx_cnt_q <= rx_cnt_q + 1'b1;
            end
        end
    end

    lsq_addr_gen #(
        .NUM_PIX (NUM_PIX),
        .IDX_W   (IDX_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_ok),
        .step   (state_q == ST_SCAN),
        .rev    (dir_rev),
        .roi    (roi_en),
        .idx    (pix_idx),
        .at_end (at_end)
    );

    lsq_bin_avg #(
        .SAMPLE_W (SAMPLE_W)
    ) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_ok),
        .shift     (cfg_shift_q),
        .in_valid  (rx_take),
        .in_data   (smp_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/line_readout_seq_chk.sv
module line_readout_seq_chk #(
    parameter int NUM_PIX = 1024
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pix_req_valid,
    input logic [$clog2(NUM_PIX)-1:0] pix_idx,
    input logic                       out_valid,
    input logic                       line_done,
    input logic                       busy,
    input logic                       cfg_err
);

    localparam int IDX_W = $clog2(NUM_PIX);

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req_valid |-> busy); // R2

    AST_IDX_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req_valid |-> (int'(pix_idx) < NUM_PIX)); // R4

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req_valid && $past(pix_req_valid)) |->
            ((pix_idx == IDX_W'($past(pix_idx) + 1'b1)) ||
             (pix_idx == IDX_W'($past(pix_idx) - 1'b1)))); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R9

    AST_DONE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> $past(out_valid)); // R9

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !busy); // R9

    AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> (!busy && !pix_req_valid)); // R7

endmodule

bind line_readout_seq line_readout_seq_chk #(.NUM_PIX(NUM_PIX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_req_valid (pix_req_valid),
    .pix_idx       (pix_idx),
    .out_valid     (out_valid),
    .line_done     (line_done),
    .busy          (busy),
    .cfg_err       (cfg_err)
);

// File: tb/line_readout_seq_test.sv
module line_readout_seq_test;

    localparam int NP = 64;
    localparam int SW = 8;
    localparam int IW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dir_rev = 1'b0;
    logic          roi_en = 1'b0;
    logic [1:0]    bin_sel = 2'd0;
    logic          diff_mode = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          pix_req_valid;
    logic [IW-1:0] pix_idx;
    logic          out_valid;
    logic [SW-1:0] out_data;
    logic          line_done;
    logic          busy;
    logic          cfg_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int    exp_req[$];
    int    exp_out[$];
    int    resp_q[$];
    bit    done_due = 0;
    bit    seen_done = 0;
    bit    inject = 0;
    bit    maxpat = 0;
    bit    cur_rev = 0;
    int    win_lo = 0;
    int    win_hi = NP - 1;
    string out_tag = "R5 average";

    always #10 clk = ~clk;

    line_readout_seq #(.NUM_PIX(NP), .SAMPLE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_rev(dir_rev),
        .roi_en(roi_en), .bin_sel(bin_sel), .diff_mode(diff_mode),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .pix_req_valid(pix_req_valid), .pix_idx(pix_idx),
        .out_valid(out_valid), .out_data(out_data),
        .line_done(line_done), .busy(busy), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int pix_val(input int p);
        return maxpat ? 255 : ((p * 37 + 11) % 256);
    endfunction

    // reference model: compares outputs every clock and answers requests
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (line_done || done_due)
                chk(line_done == done_due, "R9 line_done timing", line_done, done_due);
            if (line_done) seen_done = 1;
            done_due = 0;
            if (out_valid) begin
                if (exp_out.size() == 0) begin
                    chk(0, "R11 unexpected result", out_data, -1);
                end else begin
                    int e;
                    e = exp_out.pop_front();
                    chk(int'(out_data) == e, out_tag, out_data, e);
                    if (exp_out.size() == 0) done_due = 1;
                end
            end
            if (inject) begin
                smp_valid = 1'b1;
                smp_data  = '1;
            end else if (resp_q.size() > 0 && (cyc % 4) != 3) begin
                smp_valid = 1'b1;
                smp_data  = SW'(pix_val(resp_q.pop_front()));
            end else begin
                smp_valid = 1'b0;
            end
            if (pix_req_valid) begin
                if (exp_req.size() == 0) begin
                    chk(0, "R7 R10 stray request", pix_idx, -1);
                end else begin
                    int e;
                    e = exp_req.pop_front();
                    chk(int'(pix_idx) == e, cur_rev ? "R3 descending address" : "R2 ascending address",
                        pix_idx, e);
                    chk(int'(pix_idx) >= win_lo && int'(pix_idx) <= win_hi, "R4 address in window",
                        pix_idx, win_lo);
                end
                resp_q.push_back(int'(pix_idx));
            end
        end
    end

    task automatic run_line(input bit rev, input bit roi, input logic [1:0] bin,
                            input bit diff, input bit mp, input bit mid_start);
        int g, sh, n, acc;
        win_lo = roi ? NP / 4 : 0;
        win_hi = roi ? (3 * NP) / 4 - 1 : NP - 1;
        g  = (bin == 2'd2) ? 4 : ((bin == 2'd1) ? 2 : 1);
        sh = (bin == 2'd2) ? 2 : ((bin == 2'd1) ? 1 : 0);
        n  = win_hi - win_lo + 1;
        maxpat  = mp;
        cur_rev = rev;
        out_tag = mp ? "R12 full-scale average" : ((g > 1) ? "R6 aligned group average" : "R5 average");
        exp_req.delete();
        exp_out.delete();
        acc = 0;
        for (int k = 0; k < n; k++) begin
            int p;
            p = rev ? win_hi - k : win_lo + k;
            exp_req.push_back(p);
            acc += pix_val(p);
            if ((k % g) == g - 1) begin
                exp_out.push_back(acc >> sh);
                acc = 0;
            end
        end
        seen_done = 0;
        @(negedge clk);
        dir_rev = rev; roi_en = roi; bin_sel = bin; diff_mode = diff; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(pix_req_valid == 1'b1, rev ? "R3 first request timing" : "R2 first request timing", pix_req_valid, 1);
        chk(cfg_err == 1'b0, "R8 error cleared by accepted start", cfg_err, 0);
        if (mid_start) begin
            repeat (4) @(negedge clk);
            dir_rev = !rev; roi_en = !roi; bin_sel = 2'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R10 restart ignored while busy", busy, 1);
        end
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (seen_done) break;
        end
        chk(seen_done == 1'b1, "R9 line completed", seen_done, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after completion", busy, 0);
        chk(exp_req.size() == 0, "R4 request count", exp_req.size(), 0);
        chk(exp_out.size() == 0, "R5 result count", exp_out.size(), 0);
    endtask

    task automatic refused_start(input logic [1:0] bin, input bit diff);
        @(negedge clk);
        bin_sel = bin; diff_mode = diff; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R7 error flag set", cfg_err, 1);
        chk(busy == 1'b0, "R7 no readout started", busy, 0);
        chk(pix_req_valid == 1'b0, "R7 no request issued", pix_req_valid, 0);
        repeat (5) @(negedge clk);
        chk(cfg_err == 1'b1, "R8 error flag holds", cfg_err, 1);
        chk(busy == 1'b0, "R7 still idle", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({pix_req_valid, out_valid, line_done, busy, cfg_err} == 5'b0, "R1 outputs in reset",
            {pix_req_valid, out_valid, line_done, busy, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pix_req_valid, out_valid, line_done, busy, cfg_err} == 5'b0, "R1 outputs after reset",
            {pix_req_valid, out_valid, line_done, busy, cfg_err}, 0);

        run_line(1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);   // R2 R5 full ascending
        run_line(1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0);   // R3 R6 full descending by four
        run_line(1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0);   // R4 window ascending by two
        run_line(1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1);   // R10 restart attempt mid-line

        refused_start(2'd1, 1'b0);                      // R7 two-pixel single-ended

        inject = 1;                                     // R11 samples while idle
        repeat (3) @(negedge clk);
        inject = 0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 idle samples produce nothing", out_valid, 0);
        chk(busy == 1'b0, "R11 idle samples start nothing", busy, 0);

        run_line(1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);   // R8 R11 four-pixel single-ended allowed

        refused_start(2'd3, 1'b1);                      // R7 unused code
        run_line(1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);   // R12 full scale, one pixel
        run_line(1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0);   // R12 full scale, four pixels
        run_line(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0);   // R12 full scale, two pixels

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule